// File: doc/BRIEF.md
# Fault-Injection Run Controller and Outcome Classifier

This block runs a fault-injection campaign one run at a time. It controls the power of the node under test and the enable of the fault injector. It compares the node's output with the output of a golden reference node once per application cycle, and it assigns each finished run to one outcome class. Each application cycle is marked by a one-clock strobe. On that strobe the controller compares the message-valid flags and payloads of both nodes. It also watches the warmstart flags of the node under test and a flag that reports a failure of any other node in the set-up.

Every run ends in the same way. The controller removes power from the node under test and keeps it off for a fixed number of clocks. It then restores power so the node can coldstart. After a reload wait, and only once the node reports that it is running, the injector is enabled again. A failure of another node is the one exception: it stops the whole campaign, with power and injector both held off until reset. Saturating counters keep the number of runs in each class and the total number of runs.

Top module: `fi_run_ctrl`

## Requirements
- R1: While reset is held, power is off, the injector is off, the done pulse is low, the class output is 0 and all five counters are 0.
- R2: When a run ends, power stays off for exactly OFF_CYC clocks and then comes on. The injector stays off for at least RELOAD_CYC clocks after power returns, and after that until the running flag of the node under test is high.
- R3: On an application strobe where both nodes send a message and the payloads differ, the run ends with class code 3 (fail-silence violation).
- R4: On a strobe where the golden node sends and the node under test does not, with no warmstart seen earlier in the run or on the same clock, the run ends with class code 2 (lost message).
- R5: A warmstart flag of the node under test (internal or external) masks every later missing message. Such a run lasts the full RUN_TICKS strobes and ends with class code 1.
- R6: A payload mismatch after a warmstart still ends the run with class code 3.
- R7: A run in which every strobe carries matching messages lasts RUN_TICKS strobes and ends with class code 0.
- R8: A failure flag from another node ends the run with class code 4. Power and the injector then stay off, and no further done pulse occurs until reset.
- R9: Each done pulse lasts one clock. It coincides with power being off, and power never falls without a done pulse.
- R10: On each done pulse the counter for the reported class (codes 0 to 3) and the total counter increase by one. Each counter saturates at 2^CNT_W-1.
- R11: Messages present on clocks without an application strobe have no effect on the run.
- R12: On a strobe where the node under test sends while the golden node does not, the run ends with class code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| app_tick | input | 1 | One-clock strobe per application cycle |
| gold_vld | input | 1 | Golden node message present |
| gold_msg | input | MSG_W | Golden node payload |
| nut_vld | input | 1 | Node-under-test message present |
| nut_msg | input | MSG_W | Node-under-test payload |
| nut_ws_int | input | 1 | Warmstart raised by the node's own checks |
| nut_ws_ext | input | 1 | Warmstart signalled from outside |
| peer_fail | input | 1 | Failure of any other node |
| nut_running | input | 1 | Node under test reports it is running |
| nut_power | output | 1 | Power enable of the node under test |
| inj_enable | output | 1 | Fault injector enable |
| run_class | output | 3 | Class of the last finished run (0 ok, 1 warmstart, 2 lost, 3 violation, 4 halt) |
| run_done | output | 1 | One-clock pulse when a run ends |
| cnt_ok | output | CNT_W | Runs of class 0 |
| cnt_ws | output | CNT_W | Runs of class 1 |
| cnt_c1 | output | CNT_W | Runs of class 2 |
| cnt_c2 | output | CNT_W | Runs of class 3 |
| cnt_runs | output | CNT_W | All finished runs |

## Verification
A run-ending strobe is seen at one clock edge. The done pulse, the class code and power-off all appear at that edge, and the bench samples them on the falling edge that follows. The counters update one edge later, so the bench compares them once power has come back. The off interval and the reload wait are measured by counting falling edges with power low, and then with power high and the injector low. Every class is swept across every strobe position inside a run, with garbage messages placed between strobes, and enough lost-message runs are made to drive the counters into saturation.

// File: rtl/fi_pkg.sv
// Shared types of the fault-injection run controller.
// Assumes class codes are read by software as fixed values.
package fi_pkg;
    typedef enum logic [2:0] {
        CLS_OK = 3'd0,
        CLS_WS = 3'd1,
        CLS_C1 = 3'd2,
        CLS_C2 = 3'd3,
        CLS_F  = 3'd4
    } fi_class_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2,
        ST_HALT = 2'd3
    } fi_state_e;
endpackage

// File: rtl/fi_compare.sv
// Per-strobe message comparator.
// Produces a lost-message event and a violation event on each application strobe.
// Assumes the warmstart mask already includes a warmstart on the same clock.
module fi_compare #(
    parameter int MSG_W = 16
) (
    input  logic             tick,
    input  logic             gold_vld,
    input  logic [MSG_W-1:0] gold_msg,
    input  logic             nut_vld,
    input  logic [MSG_W-1:0] nut_msg,
    input  logic             ws_mask,
    output logic             lost_ev,
    output logic             viol_ev
);
    // Classify the messages of one strobe.
    always_comb begin
        viol_ev = tick && nut_vld && (!gold_vld || (gold_msg != nut_msg));
        lost_ev = tick && gold_vld && !nut_vld && !ws_mask;
    end
endmodule

// File: rtl/fi_seq.sv
// Run sequencer: power-off interval, reload wait, run window and end-of-run class.
// Assumes peer_fail halts everything until reset.
module fi_seq
    import fi_pkg::*;
#(
    parameter int OFF_CYC    = 4,
    parameter int RELOAD_CYC = 6,
    parameter int RUN_TICKS  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       ws_in,
    input  logic       lost_ev,
    input  logic       viol_ev,
    input  logic       peer_fail,
    input  logic       nut_running,
    output logic       ws_mask,
    output logic       nut_power,
    output logic       inj_enable,
    output logic [2:0] run_class,
    output logic       run_done
);
    localparam int TMAX = (OFF_CYC > RELOAD_CYC) ? OFF_CYC : RELOAD_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int KW   = $clog2(RUN_TICKS + 1);

    fi_state_e       state;
    logic [TW-1:0]   tmr;
    logic [KW-1:0]   tk;
    logic            ws_seen;
    fi_class_e       cls_q;

    // Warmstart seen earlier in the run or on this clock.
    assign ws_mask    = ws_seen || ws_in;
    // Power and injector follow the state.
    assign nut_power  = (state == ST_LOAD) || (state == ST_RUN);
    assign inj_enable = (state == ST_RUN);
    assign run_class  = cls_q;

    // State, timers and run outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            tmr      <= '0;
            tk       <= '0;
            ws_seen  <= 1'b0;
            cls_q    <= CLS_OK;
            run_done <= 1'b0;
        end else begin
            run_done <= 1'b0;
            if (state != ST_HALT && peer_fail) begin
                state    <= ST_HALT;
                cls_q    <= CLS_F;
                run_done <= 1'b1;
            end else begin
                case (state)
                    ST_OFF: begin
                        if (tmr == TW'(OFF_CYC - 1)) begin
                            state <= ST_LOAD;
                            tmr   <= '0;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                    ST_LOAD: begin
                        if (tmr < TW'(RELOAD_CYC - 1)) begin
                            tmr <= tmr + 1'b1;
                        end else if (nut_running) begin
                            state   <= ST_RUN;
                            tk      <= '0;
                            ws_seen <= 1'b0;
                        end
                    end
                    ST_RUN: begin
                        if (ws_in) ws_seen <= 1'b1;
                        if (tick) begin
                            if (viol_ev || lost_ev || tk == KW'(RUN_TICKS - 1)) begin
                                state    <= ST_OFF;
                                tmr      <= '0;
                                run_done <= 1'b1;
                                if (viol_ev)      cls_q <= CLS_C2;
                                else if (lost_ev) cls_q <= CLS_C1;
                                else if (ws_mask) cls_q <= CLS_WS;
                                else              cls_q <= CLS_OK;
                            end else begin
                                tk <= tk + 1'b1;
                            end
                        end
                    end
                    default: state <= ST_HALT;
                endcase
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !run_done);
    // R9
    done_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |-> !nut_power);
    // R9
    power_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nut_power) |-> run_done);
    // R2
    inj_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inj_enable) |-> $past(nut_running));
    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT) && !run_done);
endmodule

// File: rtl/fi_tally.sv
// Saturating outcome counters, one per class of codes 0..3 plus a total.
// Assumes run_class is stable while run_done is high.
module fi_tally #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_done,
    input  logic [2:0]       run_class,
    output logic [CNT_W-1:0] cnt_ok,
    output logic [CNT_W-1:0] cnt_ws,
    output logic [CNT_W-1:0] cnt_c1,
    output logic [CNT_W-1:0] cnt_c2,
    output logic [CNT_W-1:0] cnt_runs
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cls_cnt [4];
    logic [CNT_W-1:0] tot;

    // One saturating counter per class code.
    for (genvar g = 0; g < 4; g++) begin : g_cls
        always_ff @(posedge clk) begin
            if (!rst_n)
                cls_cnt[g] <= '0;
            else if (run_done && run_class == 3'(g) && cls_cnt[g] != CMAX)
                cls_cnt[g] <= cls_cnt[g] + 1'b1;
        end
    end

    // Saturating total of finished runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tot <= '0;
        else if (run_done && tot != CMAX)
            tot <= tot + 1'b1;
    end

    assign cnt_ok   = cls_cnt[0];
    assign cnt_ws   = cls_cnt[1];
    assign cnt_c1   = cls_cnt[2];
    assign cnt_c2   = cls_cnt[3];
    assign cnt_runs = tot;

    // R10
    total_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tot == CMAX) |=> (tot == CMAX));
    // R10
    total_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_done |=> $stable(tot));
endmodule

// File: rtl/fi_run_ctrl.sv
// Top of the fault-injection run controller.
// Compares golden and test-node messages per application strobe, sequences
// power and injector, and tallies run outcomes.
module fi_run_ctrl #(
    parameter int MSG_W      = 16,
    parameter int OFF_CYC    = 4,
    parameter int RELOAD_CYC = 6,
    parameter int RUN_TICKS  = 5,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             app_tick,
    input  logic             gold_vld,
    input  logic [MSG_W-1:0] gold_msg,
    input  logic             nut_vld,
    input  logic [MSG_W-1:0] nut_msg,
    input  logic             nut_ws_int,
    input  logic             nut_ws_ext,
    input  logic             peer_fail,
    input  logic             nut_running,
    output logic             nut_power,
    output logic             inj_enable,
    output logic [2:0]       run_class,
    output logic             run_done,
    output logic [CNT_W-1:0] cnt_ok,
    output logic [CNT_W-1:0] cnt_ws,
    output logic [CNT_W-1:0] cnt_c1,
    output logic [CNT_W-1:0] cnt_c2,
    output logic [CNT_W-1:0] cnt_runs
);
    logic lost_ev, viol_ev, ws_mask, run_tick, ws_in;

    // Strobes only count while a run is active.
    assign run_tick = app_tick && inj_enable;
    assign ws_in    = nut_ws_int || nut_ws_ext;

    fi_compare #(.MSG_W(MSG_W)) u_cmp (
        .tick(run_tick), .gold_vld(gold_vld), .gold_msg(gold_msg),
        .nut_vld(nut_vld), .nut_msg(nut_msg), .ws_mask(ws_mask),
        .lost_ev(lost_ev), .viol_ev(viol_ev)
    );

    fi_seq #(.OFF_CYC(OFF_CYC), .RELOAD_CYC(RELOAD_CYC), .RUN_TICKS(RUN_TICKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(run_tick), .ws_in(ws_in),
        .lost_ev(lost_ev), .viol_ev(viol_ev), .peer_fail(peer_fail),
        .nut_running(nut_running), .ws_mask(ws_mask), .nut_power(nut_power),
        .inj_enable(inj_enable), .run_class(run_class), .run_done(run_done)
    );

    fi_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .run_done(run_done), .run_class(run_class),
        .cnt_ok(cnt_ok), .cnt_ws(cnt_ws), .cnt_c1(cnt_c1), .cnt_c2(cnt_c2),
        .cnt_runs(cnt_runs)
    );
endmodule

// File: tb/tb_fi_run_ctrl.sv
module tb_fi_run_ctrl;
    localparam int MSG_W = 16, OFF_CYC = 4, RELOAD_CYC = 6, RUN_TICKS = 5, CNT_W = 4;
    localparam int CMAX = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n, app_tick, gold_vld, nut_vld, nut_ws_int, nut_ws_ext, peer_fail, nut_running;
    logic [MSG_W-1:0] gold_msg, nut_msg;
    logic nut_power, inj_enable, run_done;
    logic [2:0] run_class;
    logic [CNT_W-1:0] cnt_ok, cnt_ws, cnt_c1, cnt_c2, cnt_runs;

    int n_chk = 0, n_fail = 0;
    int m_ok = 0, m_ws = 0, m_c1 = 0, m_c2 = 0, m_tot = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fi_run_ctrl #(.MSG_W(MSG_W), .OFF_CYC(OFF_CYC), .RELOAD_CYC(RELOAD_CYC),
                  .RUN_TICKS(RUN_TICKS), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .app_tick(app_tick), .gold_vld(gold_vld),
        .gold_msg(gold_msg), .nut_vld(nut_vld), .nut_msg(nut_msg),
        .nut_ws_int(nut_ws_int), .nut_ws_ext(nut_ws_ext), .peer_fail(peer_fail),
        .nut_running(nut_running), .nut_power(nut_power), .inj_enable(inj_enable),
        .run_class(run_class), .run_done(run_done), .cnt_ok(cnt_ok), .cnt_ws(cnt_ws),
        .cnt_c1(cnt_c1), .cnt_c2(cnt_c2), .cnt_runs(cnt_runs)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic idle_inputs();
        app_tick = 0; gold_vld = 0; nut_vld = 0; nut_ws_int = 0; nut_ws_ext = 0;
        gold_msg = '0; nut_msg = '0; peer_fail = 0;
    endtask

    // kind: 0 clean, 1 warmstart, 2 lost, 3 mismatch, 4 warmstart then mismatch, 5 unsolicited
    task automatic do_run(input int kind, input int pos, input int rid);
        int end_t, exp_cls, off_n, ld_n;
        bit ended;
        string tag;
        logic [MSG_W-1:0] gd;
        end_t = RUN_TICKS - 1; exp_cls = 0; tag = "R7";
        case (kind)
            1: begin exp_cls = 1; tag = "R5"; end
            2: begin exp_cls = 2; end_t = pos; tag = "R4"; end
            3: begin exp_cls = 3; end_t = pos; tag = "R3"; end
            4: if (pos < RUN_TICKS - 1) begin exp_cls = 3; end_t = pos + 1; tag = "R6"; end
               else begin exp_cls = 1; tag = "R5"; end
            5: begin exp_cls = 3; end_t = pos; tag = "R12"; end
            default: ;
        endcase
        ended = 0;
        for (int t = 0; t < RUN_TICKS; t++) begin
            if (!ended) begin
                gd = MSG_W'(t * 37 + rid * 11 + 5);
                // R11: garbage between strobes
                app_tick = 0; gold_vld = 0; nut_vld = 1; nut_msg = '1;
                @(negedge clk);
                chk("R11 no end off-strobe", run_done, 0);
                app_tick = 1; gold_vld = 1; gold_msg = gd; nut_msg = gd; nut_vld = 1;
                if ((kind == 1 || kind == 4) && t >= pos) nut_vld = 0;
                if ((kind == 1 || kind == 4) && t == pos) begin
                    if (pos % 2 == 0) nut_ws_int = 1; else nut_ws_ext = 1;
                end
                if (kind == 4 && t == pos + 1) begin nut_vld = 1; nut_msg = gd ^ 16'h0100; end
                if (kind == 2 && t == pos) nut_vld = 0;
                if (kind == 3 && t == pos) nut_msg = gd ^ 16'h0001;
                if (kind == 5 && t == pos) gold_vld = 0;
                @(negedge clk);
                idle_inputs();
                chk({tag, " done timing"}, run_done, (t == end_t) ? 1 : 0);
                if (t == end_t) begin
                    chk({tag, " class"}, run_class, exp_cls);
                    chk("R9 power off at done", nut_power, 0);
                    ended = 1;
                end
            end
        end
        case (exp_cls)
            0: m_ok = sat(m_ok + 1);
            1: m_ws = sat(m_ws + 1);
            2: m_c1 = sat(m_c1 + 1);
            default: m_c2 = sat(m_c2 + 1);
        endcase
        m_tot = sat(m_tot + 1);
        off_n = 0;
        while (!nut_power) begin off_n++; @(negedge clk); end
        chk("R2 off interval", off_n, OFF_CYC);
        chk("R10 cnt_ok", cnt_ok, m_ok);
        chk("R10 cnt_ws", cnt_ws, m_ws);
        chk("R10 cnt_c1", cnt_c1, m_c1);
        chk("R10 cnt_c2", cnt_c2, m_c2);
        chk("R10 cnt_runs", cnt_runs, m_tot);
        ld_n = 0;
        while (!inj_enable) begin ld_n++; @(negedge clk); end
        chk("R2 reload wait", ld_n, RELOAD_CYC);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int rid, bad;
        idle_inputs();
        rst_n = 0; nut_running = 0;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 power", nut_power, 0);
        chk("R1 inj", inj_enable, 0);
        chk("R1 done", run_done, 0);
        chk("R1 class", run_class, 0);
        chk("R1 counters", int'(cnt_ok) + cnt_ws + cnt_c1 + cnt_c2 + cnt_runs, 0);
        rst_n = 1;
        // R2: injector waits for running flag
        repeat (30) @(negedge clk);
        chk("R2 power on after off", nut_power, 1);
        chk("R2 inj held for running", inj_enable, 0);
        nut_running = 1;
        @(negedge clk);
        chk("R2 inj after running", inj_enable, 1);
        rid = 0;
        for (int k = 0; k < 6; k++)
            for (int p = 0; p < RUN_TICKS; p++) begin
                do_run(k, p, rid);
                rid++;
            end
        // R10: saturate the lost-message counter
        for (int i = 0; i < 12; i++) begin
            do_run(2, i % RUN_TICKS, rid);
            rid++;
        end
        // R8: peer failure halts everything
        peer_fail = 1;
        @(negedge clk);
        peer_fail = 0;
        chk("R8 done", run_done, 1);
        chk("R8 class", run_class, 4);
        chk("R8 power", nut_power, 0);
        chk("R8 inj", inj_enable, 0);
        m_tot = sat(m_tot + 1);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            app_tick = 1; nut_vld = 1; nut_msg = 16'h1234; gold_vld = 1; gold_msg = 16'h4321;
            peer_fail = (i == 10);
            @(negedge clk);
            if (run_done || nut_power || inj_enable) bad++;
        end
        idle_inputs();
        chk("R8 halt held", bad, 0);
        chk("R8 class held", run_class, 4);
        chk("R10 total after halt", cnt_runs, m_tot);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule